// File: doc/BRIEF.md
# Per-Peripheral Line Interrupt Status Block

This block watches eight asynchronous interrupt lines that belong to one peripheral. Each line is either edge or level sensitive. Two independent polarity selects qualify it. For an edge line the "high" select catches rising transitions and the "low" select catches falling ones, and setting both catches either edge. For a level line exactly one select must be set, and it gives active-high or active-low behaviour. A qualified event sets a sticky pending bit for its line. A separate enable mask gates the pending bits into a single summary interrupt that goes to an upstream arbiter.

Software reaches the block through a byte-wide register window with an address, write data, read data and single-cycle read and write strobes. A multi-byte transfer arrives as single-byte accesses at rising addresses. The pending-clear byte therefore sits directly below the enable-set byte, so one two-byte write can flush a stale event and arm the line in a single burst. Pending bits and enable bits are changed only through write-1 set and clear addresses.

Top module: `line_irq_status`

## Requirements
- R1: After reset, the mode, both polarity selects, the pending bits, the enable mask, the read data and `irq_out` are all zero, so no line can latch.
- R2: Each input passes through two synchronizer flops. A level change driven between two clock edges can raise `irq_out` no earlier than the third following edge.
- R3: Clearing a line's mode bit (offset 0x11) makes it level sensitive. With only its high select (0x12) set it latches while the synchronized input is 1. With only its low select (0x13) set it latches while the input is 0. While the level stays active it latches again in the cycle after a clear.
- R4: A level-mode line with both polarity selects set never latches.
- R5: Setting a line's mode bit makes it edge sensitive. The high select latches on a rising edge, the low select on a falling edge, and both together on either edge. Each edge latches once.
- R6: Writing to 0x14 clears the pending bits written as 1 and leaves bits written as 0 unchanged. If a clear and an event hit the same line in the same cycle, the line stays pending.
- R7: Writing to 0x15 sets the enable bits written as 1, and writing to 0x16 clears the enable bits written as 1. Bits written as 0 are unchanged. Reading 0x15 returns the enable mask.
- R8: `irq_out` is high exactly when some line is both pending and enabled. A line latches whether or not it is enabled.
- R9: Reading 0x10 returns, for each line, (high select AND synchronized input) OR (low select AND NOT synchronized input), and changes no state.
- R10: Reads of 0x11, 0x12 and 0x13 return the mode and polarity selects, and a read of 0x18 returns the pending bits. Read data is registered: it appears in the cycle after `bus_rd` and holds while no read occurs. Reads of 0x14, 0x16 and of unmapped addresses return 0.
- R11: Writing 0x14 and then 0x15 on consecutive cycles with the same mask arms a line that already holds a stale pending event, and `irq_out` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 8 | Asynchronous interrupt lines, bit n is line n |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Summary interrupt to the arbiter |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are valid whenever a strobe is high. They also assume the lines reach the pending logic only through the synchronizer, so every property is stated against the synchronized event vector and never against the raw pins. The stimulus drives the strobes and the lines only at falling clock edges and holds each strobe for one cycle. This keeps every sample clean and lets back-to-back writes form the two-byte clear-then-enable burst. The lines are held steady for several cycles between changes, so each edge and each level is seen exactly as the requirements describe.

// File: rtl/line_irq_status.sv
module line_irq_status #(
  parameter int NLINES = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq_out
);

  localparam logic [AW-1:0] A_LIVE = BASE;
  localparam logic [AW-1:0] A_MODE = BASE + AW'(1);
  localparam logic [AW-1:0] A_HI   = BASE + AW'(2);
  localparam logic [AW-1:0] A_LO   = BASE + AW'(3);
  localparam logic [AW-1:0] A_ACK  = BASE + AW'(4);
  localparam logic [AW-1:0] A_ENS  = BASE + AW'(5);
  localparam logic [AW-1:0] A_ENC  = BASE + AW'(6);
  localparam logic [AW-1:0] A_PEND = BASE + AW'(8);

  logic [NLINES-1:0] sync1_q, sync2_q, prev_q;
  logic [NLINES-1:0] mode_q, hi_q, lo_q;
  logic [NLINES-1:0] pend_q, en_q, rdata_q;
  logic [NLINES-1:0] live, rise, fall, evt;
  logic [NLINES-1:0] ack_m, ens_m, enc_m;

  assign live = (hi_q & sync2_q) | (lo_q & ~sync2_q);
  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign evt  = (mode_q & ((hi_q & rise) | (lo_q & fall)))
              | (~mode_q & (hi_q ^ lo_q) & live);

  assign ack_m = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
  assign ens_m = (bus_wr && bus_addr == A_ENS) ? bus_wdata : '0;
  assign enc_m = (bus_wr && bus_addr == A_ENC) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata;
      if (bus_addr == A_HI)   hi_q   <= bus_wdata;
      if (bus_addr == A_LO)   lo_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_m) | evt;
      en_q   <= (en_q | ens_m) & ~enc_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_LIVE:  rdata_q <= live;
        A_MODE:  rdata_q <= mode_q;
        A_HI:    rdata_q <= hi_q;
        A_LO:    rdata_q <= lo_q;
        A_ENS:   rdata_q <= en_q;
        A_PEND:  rdata_q <= pend_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = |(pend_q & en_q);

endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker #(
  parameter int NLINES = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic [NLINES-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [NLINES-1:0] bus_rdata,
  input logic              irq_out,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] en,
  input logic [NLINES-1:0] evt,
  input logic [NLINES-1:0] mode,
  input logic [NLINES-1:0] hi,
  input logic [NLINES-1:0] lo
);

  localparam logic [AW-1:0] A_ACK = BASE + AW'(4);
  localparam logic [AW-1:0] A_ENS = BASE + AW'(5);
  localparam logic [AW-1:0] A_ENC = BASE + AW'(6);

  assert_illegal_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~mode & hi & lo) == '0);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ACK && (bus_wdata & evt) == '0)
      |=> (pend & $past(bus_wdata)) == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_ACK) |=> (pend & $past(pend)) == $past(pend));

  assert_event_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (pend & $past(evt)) == $past(evt));

  assert_enable_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENS) |=> (en & $past(bus_wdata)) == $past(bus_wdata));

  assert_enable_all_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENC && bus_wdata == {NLINES{1'b1}}) |=> !irq_out);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind line_irq_status line_irq_checker #(.NLINES(NLINES), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .pend(pend_q), .en(en_q), .evt(evt), .mode(mode_q), .hi(hi_q), .lo(lo_q)
);

// File: tb/test_line_irq_status.sv
`timescale 1ns/1ps
module test_line_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] line_in = '0, bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq_out;
  integer checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  line_irq_status i_line_irq_status (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_mode = '0, m_hi = '0, m_lo = '0;
  logic [7:0] m_pend = '0, m_en = '0, m_rd = '0, m_ev = '0, m_rt = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_mode = '0; m_hi = '0; m_lo = '0;
      m_pend = '0; m_en = '0; m_rd = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        m_rt[i] = (m_hi[i] && m_s2[i]) || (m_lo[i] && !m_s2[i]);
        if (m_mode[i])
          m_ev[i] = (m_hi[i] && m_s2[i] && !m_prev[i]) || (m_lo[i] && !m_s2[i] && m_prev[i]);
        else if (m_hi[i] != m_lo[i])
          m_ev[i] = m_rt[i];
        else
          m_ev[i] = 1'b0;
      end
      if (bus_rd) begin
        case (bus_addr)
          8'h10: m_rd = m_rt;
          8'h11: m_rd = m_mode;
          8'h12: m_rd = m_hi;
          8'h13: m_rd = m_lo;
          8'h15: m_rd = m_en;
          8'h18: m_rd = m_pend;
          default: m_rd = '0;
        endcase
      end
      for (int i = 0; i < 8; i++) begin
        if (bus_wr && bus_addr == 8'h14 && bus_wdata[i]) m_pend[i] = 1'b0;
        if (m_ev[i]) m_pend[i] = 1'b1;
        if (bus_wr && bus_addr == 8'h15 && bus_wdata[i]) m_en[i] = 1'b1;
        if (bus_wr && bus_addr == 8'h16 && bus_wdata[i]) m_en[i] = 1'b0;
      end
      if (bus_wr && bus_addr == 8'h11) m_mode = bus_wdata;
      if (bus_wr && bus_addr == 8'h12) m_hi = bus_wdata;
      if (bus_wr && bus_addr == 8'h13) m_lo = bus_wdata;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = line_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_out == ((m_pend & m_en) != 0), "R8 irq vs model", {7'd0, irq_out}, {7'd0, (m_pend & m_en) != 0});
      chk(bus_rdata == m_rd, "R10 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v === e, tag, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(irq_out === 1'b0, "R1 irq after reset", {7'd0, irq_out}, 8'h00);
    chk(bus_rdata === 8'h00, "R1 rdata after reset", bus_rdata, 8'h00);
    expect_rd(8'h11, 8'h00, "R1 mode reset");
    expect_rd(8'h12, 8'h00, "R1 high select reset");
    expect_rd(8'h13, 8'h00, "R1 low select reset");
    expect_rd(8'h15, 8'h00, "R1 enable reset");
    expect_rd(8'h18, 8'h00, "R1 pending reset");
    expect_rd(8'h14, 8'h00, "R10 write-only reads zero");
    expect_rd(8'h17, 8'h00, "R10 unmapped reads zero");

    wr(8'h11, 8'h38);
    wr(8'h12, 8'h2D);
    wr(8'h13, 8'h36);
    expect_rd(8'h11, 8'h38, "R10 mode readback");
    expect_rd(8'h12, 8'h2D, "R10 high select readback");
    expect_rd(8'h13, 8'h36, "R10 low select readback");
    idle(4);
    expect_rd(8'h18, 8'h02, "R3 active-low level latch");
    expect_rd(8'h10, 8'h36, "R9 live status inputs low");

    line_in = 8'h01; idle(4);
    expect_rd(8'h18, 8'h03, "R3 active-high level latch");
    expect_rd(8'h10, 8'h37, "R9 live status line0 high");
    expect_rd(8'h18, 8'h03, "R9 live read left pending unchanged");

    wr(8'h14, 8'h03);
    expect_rd(8'h18, 8'h03, "R6 set wins over clear, R3 relatch");

    line_in = 8'h02; idle(4);
    wr(8'h14, 8'h00);
    expect_rd(8'h18, 8'h03, "R6 zero bits leave pending");
    wr(8'h14, 8'h03);
    expect_rd(8'h18, 8'h00, "R6 clear with levels inactive");

    line_in = 8'h06; idle(4);
    line_in = 8'h02; idle(4);
    expect_rd(8'h18, 8'h00, "R4 both selects in level mode");

    line_in = 8'h3A; idle(4);
    expect_rd(8'h18, 8'h28, "R5 rising edge lines 3 and 5");
    wr(8'h14, 8'hFF);
    idle(2);
    expect_rd(8'h18, 8'h00, "R5 edge latches once");
    line_in = 8'h02; idle(4);
    expect_rd(8'h18, 8'h30, "R5 falling edge lines 4 and 5");

    chk(irq_out === 1'b0, "R8 pending but disabled", {7'd0, irq_out}, 8'h00);
    wr(8'h15, 8'h10);
    expect_rd(8'h15, 8'h10, "R7 enable set readback");
    chk(irq_out === 1'b1, "R8 pending and enabled", {7'd0, irq_out}, 8'h01);
    wr(8'h16, 8'h00);
    wr(8'h15, 8'h00);
    expect_rd(8'h15, 8'h10, "R7 zero bits leave enable");
    wr(8'h16, 8'h10);
    expect_rd(8'h15, 8'h00, "R7 enable clear");
    chk(irq_out === 1'b0, "R8 disabled again", {7'd0, irq_out}, 8'h00);
    wr(8'h14, 8'hFF);

    wr(8'h15, 8'h01);
    line_in = 8'h03;
    @(negedge clk);
    chk(irq_out === 1'b0, "R2 one edge after change", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    chk(irq_out === 1'b0, "R2 two edges after change", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    chk(irq_out === 1'b1, "R2 three edges after change", {7'd0, irq_out}, 8'h01);
    line_in = 8'h02; idle(4);
    wr(8'h14, 8'h01);
    wr(8'h16, 8'h01);

    line_in = 8'h0A; idle(4);
    expect_rd(8'h18, 8'h08, "R11 stale event pending");
    wr(8'h14, 8'h08);
    wr(8'h15, 8'h08);
    for (int k = 0; k < 3; k++) begin
      chk(irq_out === 1'b0, "R11 burst arm keeps irq low", {7'd0, irq_out}, 8'h00);
      @(negedge clk);
    end
    expect_rd(8'h15, 8'h08, "R11 line armed");
    line_in = 8'h02; idle(4);
    line_in = 8'h0A; idle(4);
    chk(irq_out === 1'b1, "R11 fresh edge fires after arm", {7'd0, irq_out}, 8'h01);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule